// File: doc/BRIEF.md
# Sleep Wake-Up and Sleep-Reject Controller

This block decides when a sleeping chip must wake, and whether a request to sleep should be refused. It gathers eleven wake sources into one wake event: two external pad triggers (one selected pad, and a combination of several pads), a general-purpose input line, a timer match, an SDIO command pulse, Wi-Fi, two UART receive lines, touch, the low-power co-processor and Bluetooth. Each source passes only if its enable bit is set and the current sleep mode allows it.

When software asks for sleep, the block looks at the sources armed for rejection. If one of them is active in that cycle, it refuses the request. Otherwise it grants sleep and stays asleep until a permitted source fires. It then gives a one-cycle wake pulse. Two sticky cause registers record which sources caused a wake and which caused a refusal. Software clears both with one clear strobe.

Level inputs pass through two flops before they are used. The UART receive lines are watched for rising edges while asleep, and a UART source fires once enough edges have been seen.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A one-cycle `sleep_req_i` taken while awake with `req_mode_i` of 1 (light), 2 (deep) or 3 (hibernation) gives exactly one one-cycle pulse, either `sleep_grant_o` or `sleep_rej_o`. A grant raises `asleep_o`. A request with `req_mode_i` = 0, or any request made while asleep, has no effect.
- R2: A request is refused when any source with its `rej_ena_i` bit set is active and the reject enable for the requested mode is set. Light sleep uses `rej_light_en_i`; deep sleep and hibernation use `rej_deep_en_i`. The UART sources (bits 6 and 7) never cause a refusal.
- R3: `rej_cause_o` ORs in the refusing sources on each refusal and keeps them until a `cause_clr_i` pulse sets it to zero.
- R4: Source bit positions, used by `wake_ena_i`, `rej_ena_i` and both cause registers, are: 0 single pad, 1 multi-pad, 2 GPIO, 3 timer, 4 SDIO, 5 Wi-Fi, 6 UART0, 7 UART1, 8 touch, 9 co-processor, 10 Bluetooth.
- R5: In light sleep every source may wake the chip. In deep sleep only bits 0, 1, 2, 3, 8 and 9 may wake it. In hibernation only bits 1 and 3 may wake it. A source that the mode does not permit neither wakes the chip nor appears in `wake_cause_o`.
- R6: The single-pad source fires when pad `ext0_sel_i` equals `ext0_pol_i` (1 means high, 0 means low). A select value of 18 or above never fires.
- R7: The multi-pad source with `ext1_pol_i` = 1 fires when any pad in `ext1_map_i` is high. With `ext1_pol_i` = 0 it fires only when every mapped pad is low. An empty map never fires.
- R8: Each UART source fires once it has seen at least `uart_thr_i` + 2 rising edges on its receive line while asleep. The counter clears when sleep is granted and saturates instead of wrapping.
- R9: A one-cycle `sdio_cmd_i` pulse while asleep in light sleep wakes the chip.
- R10: On a wake, `wake_cause_o` ORs in the enabled, mode-permitted sources that were active and keeps them until a `cause_clr_i` pulse sets it to zero.
- R11: A wake gives a one-cycle `wake_o` pulse and drops `asleep_o` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep request strobe |
| req_mode_i | input | 2 | Requested mode: 1 light, 2 deep, 3 hibernation |
| wake_ena_i | input | 11 | Wake enable mask |
| rej_ena_i | input | 11 | Reject enable mask |
| rej_light_en_i | input | 1 | Allow refusal of light sleep |
| rej_deep_en_i | input | 1 | Allow refusal of deep sleep and hibernation |
| ext0_sel_i | input | 5 | Pad index for the single-pad source |
| ext0_pol_i | input | 1 | Single-pad trigger level |
| ext1_map_i | input | 18 | Pad bitmap for the multi-pad source |
| ext1_pol_i | input | 1 | Multi-pad mode: 1 any high, 0 all low |
| uart_thr_i | input | 10 | UART edge threshold |
| pad_i | input | 18 | Pad levels |
| gpio_i | input | 1 | GPIO wake level |
| timer_i | input | 1 | Timer match level |
| sdio_cmd_i | input | 1 | SDIO command-seen pulse |
| wifi_i | input | 1 | Wi-Fi wake level |
| uart_rxd_i | input | 2 | UART receive lines |
| touch_i | input | 1 | Touch wake level |
| ulp_i | input | 1 | Co-processor wake level |
| bt_i | input | 1 | Bluetooth wake level |
| cause_clr_i | input | 1 | Clear both cause registers |
| asleep_o | output | 1 | Sleep state |
| wake_o | output | 1 | Wake pulse |
| sleep_grant_o | output | 1 | Grant pulse |
| sleep_rej_o | output | 1 | Refusal pulse |
| wake_cause_o | output | 11 | Sticky wake causes |
| rej_cause_o | output | 11 | Sticky refusal causes |

## Verification
The assertions assume that `sdio_cmd_i` is already synchronous to the clock. They also assume that `cause_clr_i` is a strobe that software may raise at any time. The hibernation check assumes that the wake cause was cleared before the sleep began.

The stimulus changes level sources and configuration only between edges. It holds each level for several cycles, longer than the two-flop path, before issuing a request. It clears the cause registers before each scenario, except in the scenarios that deliberately test accumulation.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  localparam int NSRC   = 11;
  localparam int NPAD   = 18;
  localparam int PSEL_W = 5;
  localparam int THR_W  = 10;
  localparam int NUART  = 2;

  localparam int S_EXT0  = 0;
  localparam int S_EXT1  = 1;
  localparam int S_GPIO  = 2;
  localparam int S_TIMER = 3;
  localparam int S_SDIO  = 4;
  localparam int S_WIFI  = 5;
  localparam int S_UART0 = 6;
  localparam int S_UART1 = 7;
  localparam int S_TOUCH = 8;
  localparam int S_ULP   = 9;
  localparam int S_BT    = 10;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2,
    MODE_HIB   = 2'd3
  } slp_mode_e;

  localparam src_vec_t ALLOW_LIGHT = '1;
  localparam src_vec_t ALLOW_DEEP  = src_vec_t'((1 << S_EXT0) | (1 << S_EXT1) | (1 << S_GPIO) |
                                                (1 << S_TIMER) | (1 << S_TOUCH) | (1 << S_ULP));
  localparam src_vec_t ALLOW_HIB   = src_vec_t'((1 << S_EXT1) | (1 << S_TIMER));
  localparam src_vec_t NO_REJECT   = src_vec_t'((1 << S_UART0) | (1 << S_UART1));

  function automatic src_vec_t allow_mask(slp_mode_e m);
    case (m)
      MODE_LIGHT: allow_mask = ALLOW_LIGHT;
      MODE_DEEP:  allow_mask = ALLOW_DEEP;
      MODE_HIB:   allow_mask = ALLOW_HIB;
      default:    allow_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/slp_pad_wake.sv
module slp_pad_wake #(
  parameter int NPAD   = 18,
  parameter int PSEL_W = 5
) (
  input  logic [NPAD-1:0]   pad_i,
  input  logic [PSEL_W-1:0] ext0_sel_i,
  input  logic              ext0_pol_i,
  input  logic [NPAD-1:0]   ext1_map_i,
  input  logic              ext1_pol_i,
  output logic              ext0_o,
  output logic              ext1_o
);
  logic [NPAD-1:0] picked;
  logic            any_hi, all_lo;

  // out-of-range select matches no pad and never fires
  always_comb begin
    ext0_o = 1'b0;
    for (int i = 0; i < NPAD; i++)
      if (ext0_sel_i == PSEL_W'(i)) ext0_o = (pad_i[i] == ext0_pol_i);
  end

  assign picked = pad_i & ext1_map_i;
  assign any_hi = |picked;
  assign all_lo = ~any_hi & (|ext1_map_i);
  assign ext1_o = ext1_pol_i ? any_hi : all_lo;
endmodule

// File: rtl/slp_uart_act.sv
module slp_uart_act #(
  parameter int THR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic             count_en_i,
  input  logic             clr_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  localparam int CNT_W = THR_W + 1;

  logic             rxd_prev;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] goal;
  logic             rise;

  assign rise = rxd_i & ~rxd_prev;
  assign goal = CNT_W'(thr_i) + CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rxd_prev <= 1'b0;
    else         rxd_prev <= rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (count_en_i && rise && ~&cnt_q)  cnt_q <= cnt_q + CNT_W'(1);

  assign hit_o = (cnt_q >= goal);
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic [1:0]        req_mode_i,
  input  logic [NSRC-1:0]   wake_ena_i,
  input  logic [NSRC-1:0]   rej_ena_i,
  input  logic              rej_light_en_i,
  input  logic              rej_deep_en_i,
  input  logic [PSEL_W-1:0] ext0_sel_i,
  input  logic              ext0_pol_i,
  input  logic [NPAD-1:0]   ext1_map_i,
  input  logic              ext1_pol_i,
  input  logic [THR_W-1:0]  uart_thr_i,
  input  logic [NPAD-1:0]   pad_i,
  input  logic              gpio_i,
  input  logic              timer_i,
  input  logic              sdio_cmd_i,
  input  logic              wifi_i,
  input  logic [NUART-1:0]  uart_rxd_i,
  input  logic              touch_i,
  input  logic              ulp_i,
  input  logic              bt_i,
  input  logic              cause_clr_i,
  output logic              asleep_o,
  output logic              wake_o,
  output logic              sleep_grant_o,
  output logic              sleep_rej_o,
  output logic [NSRC-1:0]   wake_cause_o,
  output logic [NSRC-1:0]   rej_cause_o
);
  localparam int LVL_W = NPAD + 6 + NUART;

  logic [LVL_W-1:0] lvl_raw, lvl_s;
  logic [NPAD-1:0]  pad_s;
  logic [NUART-1:0] rxd_s, uart_hit;
  logic             gpio_s, timer_s, wifi_s, touch_s, ulp_s, bt_s;
  logic             ext0_hit, ext1_hit;
  src_vec_t         src, wake_hit, rej_hit;
  slp_mode_e        mode_q, req_mode;
  logic             asleep_q, req_ok, rej_mode_en, grant_now;
  logic             wake_q, grant_q, rej_q;
  src_vec_t         wake_cause_q, rej_cause_q;

  assign lvl_raw = {uart_rxd_i, bt_i, ulp_i, touch_i, wifi_i, timer_i, gpio_i, pad_i};

  slp_sync #(.W(LVL_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl_raw),
    .q_o   (lvl_s)
  );

  assign {rxd_s, bt_s, ulp_s, touch_s, wifi_s, timer_s, gpio_s, pad_s} = lvl_s;

  slp_pad_wake #(.NPAD(NPAD), .PSEL_W(PSEL_W)) u_pad (
    .pad_i     (pad_s),
    .ext0_sel_i(ext0_sel_i),
    .ext0_pol_i(ext0_pol_i),
    .ext1_map_i(ext1_map_i),
    .ext1_pol_i(ext1_pol_i),
    .ext0_o    (ext0_hit),
    .ext1_o    (ext1_hit)
  );

  for (genvar u = 0; u < NUART; u++) begin : g_uart
    slp_uart_act #(.THR_W(THR_W)) u_act (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rxd_i     (rxd_s[u]),
      .count_en_i(asleep_q),
      .clr_i     (grant_now),
      .thr_i     (uart_thr_i),
      .hit_o     (uart_hit[u])
    );
  end

  always_comb begin
    src          = '0;
    src[S_EXT0]  = ext0_hit;
    src[S_EXT1]  = ext1_hit;
    src[S_GPIO]  = gpio_s;
    src[S_TIMER] = timer_s;
    src[S_SDIO]  = sdio_cmd_i;
    src[S_WIFI]  = wifi_s;
    src[S_UART0] = uart_hit[0];
    src[S_UART1] = uart_hit[1];
    src[S_TOUCH] = touch_s;
    src[S_ULP]   = ulp_s;
    src[S_BT]    = bt_s;
  end

  assign req_mode    = slp_mode_e'(req_mode_i);
  assign req_ok      = sleep_req_i & ~asleep_q & (req_mode != MODE_NONE);
  assign rej_mode_en = (req_mode == MODE_LIGHT) ? rej_light_en_i : rej_deep_en_i;
  assign rej_hit     = rej_mode_en ? (src & rej_ena_i & ~NO_REJECT) : '0;
  assign wake_hit    = asleep_q ? (src & wake_ena_i & allow_mask(mode_q)) : '0;
  assign grant_now   = req_ok & ~(|rej_hit);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      mode_q   <= MODE_NONE;
      wake_q   <= 1'b0;
      grant_q  <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      wake_q  <= 1'b0;
      grant_q <= 1'b0;
      rej_q   <= 1'b0;
      if (|wake_hit) begin
        asleep_q <= 1'b0;
        wake_q   <= 1'b1;
      end else if (req_ok) begin
        if (|rej_hit) begin
          rej_q <= 1'b1;
        end else begin
          grant_q  <= 1'b1;
          asleep_q <= 1'b1;
          mode_q   <= req_mode;
        end
      end
    end

  // clear wins over history; a same-cycle event reloads the fresh causes
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          wake_cause_q <= '0;
    else if (cause_clr_i) wake_cause_q <= wake_hit;
    else if (|wake_hit)   wake_cause_q <= wake_cause_q | wake_hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               rej_cause_q <= '0;
    else if (cause_clr_i)      rej_cause_q <= (req_ok && !(|wake_hit)) ? rej_hit : '0;
    else if (req_ok && !(|wake_hit) && (|rej_hit))
                               rej_cause_q <= rej_cause_q | rej_hit;

  assign asleep_o      = asleep_q;
  assign wake_o        = wake_q;
  assign sleep_grant_o = grant_q;
  assign sleep_rej_o   = rej_q;
  assign wake_cause_o  = wake_cause_q;
  assign rej_cause_o   = rej_cause_q;
endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk
  import slp_wake_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cause_clr_i,
  input logic            asleep_o,
  input logic            wake_o,
  input logic            sleep_grant_o,
  input logic            sleep_rej_o,
  input logic [NSRC-1:0] wake_cause_o,
  input logic [NSRC-1:0] rej_cause_o,
  input logic [1:0]      mode_q
);
  p_grant_rej_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sleep_grant_o && sleep_rej_o));

  p_grant_sleeps_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_grant_o |-> asleep_o && !$past(asleep_o));

  p_rej_awake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_rej_o |-> !asleep_o && (rej_cause_o != '0));

  p_no_uart_rej_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_cause_o & NO_REJECT) == '0);

  p_rej_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cause_clr_i) && !sleep_rej_o |-> rej_cause_o == '0);

  p_wake_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cause_clr_i) && !wake_o |-> wake_cause_o == '0);

  p_hib_sources_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o && (mode_q == 2'd3) && ($past(wake_cause_o) == '0) |->
      (wake_cause_o & ~ALLOW_HIB) == '0);

  p_wake_from_sleep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !asleep_o && $past(asleep_o) && (wake_cause_o != '0));

  p_wake_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

bind slp_wake_ctrl slp_wake_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cause_clr_i  (cause_clr_i),
  .asleep_o     (asleep_o),
  .wake_o       (wake_o),
  .sleep_grant_o(sleep_grant_o),
  .sleep_rej_o  (sleep_rej_o),
  .wake_cause_o (wake_cause_o),
  .rej_cause_o  (rej_cause_o),
  .mode_q       (mode_q)
);

// File: tb/sim_slp_wake_ctrl.sv
module sim_slp_wake_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sleep_req = 0, rej_light_en = 0, rej_deep_en = 0;
  logic [1:0]  req_mode = 0;
  logic [10:0] wake_ena = '1, rej_ena = '0;
  logic [4:0]  ext0_sel = 5'd31;
  logic        ext0_pol = 1, ext1_pol = 1;
  logic [17:0] ext1_map = '0, pad = '0;
  logic [9:0]  uart_thr = 10'd3;
  logic        gpio = 0, timer = 0, sdio = 0, wifi = 0, touch = 0, ulp = 0, bt = 0, cause_clr = 0;
  logic [1:0]  rxd = '0;
  logic        asleep, wake, grant, rej;
  logic [10:0] wake_cause, rej_cause;

  int n_cmp = 0, n_bad = 0;

  typedef struct { int k; logic [10:0] c; string tag; } exp_t;
  exp_t exq[$];

  always #5 clk = ~clk;

  slp_wake_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .req_mode_i(req_mode),
    .wake_ena_i(wake_ena), .rej_ena_i(rej_ena), .rej_light_en_i(rej_light_en),
    .rej_deep_en_i(rej_deep_en), .ext0_sel_i(ext0_sel), .ext0_pol_i(ext0_pol),
    .ext1_map_i(ext1_map), .ext1_pol_i(ext1_pol), .uart_thr_i(uart_thr), .pad_i(pad),
    .gpio_i(gpio), .timer_i(timer), .sdio_cmd_i(sdio), .wifi_i(wifi), .uart_rxd_i(rxd),
    .touch_i(touch), .ulp_i(ulp), .bt_i(bt), .cause_clr_i(cause_clr),
    .asleep_o(asleep), .wake_o(wake), .sleep_grant_o(grant), .sleep_rej_o(rej),
    .wake_cause_o(wake_cause), .rej_cause_o(rej_cause)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: 0 grant, 1 reject, 2 wake
  task automatic take(int k, logic [10:0] c);
    exp_t e;
    if (exq.size() == 0) begin
      chk(0, "R1 unexpected event", k, -1);
      return;
    end
    e = exq.pop_front();
    chk(e.k == k, {e.tag, " kind"}, k, e.k);
    if (k != 0) chk(c == e.c, {e.tag, " cause"}, c, e.c);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (grant) take(0, '0);
    if (rej)   take(1, rej_cause);
    if (wake)  take(2, wake_cause);
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic expect_ev(int k, logic [10:0] c, string tag);
    exp_t e; e.k = k; e.c = c; e.tag = tag; exq.push_back(e);
  endtask
  task automatic req(logic [1:0] m);
    @(negedge clk); sleep_req = 1; req_mode = m;
    @(negedge clk); sleep_req = 0; req_mode = 0;
    tick(2);
  endtask
  task automatic wait_awake(string tag);
    int n = 0;
    while (asleep && n < 200) begin tick(1); n++; end
    chk(!asleep, {tag, " wake"}, asleep, 0);
    tick(2);
  endtask
  task automatic stay_asleep(string tag);
    tick(10);
    chk(asleep, {tag, " stays asleep"}, asleep, 1);
  endtask
  task automatic clr_causes(string tag);
    @(negedge clk); cause_clr = 1;
    @(negedge clk); cause_clr = 0;
    chk(wake_cause == 0 && rej_cause == 0, {tag, " cleared"}, {wake_cause, rej_cause}, 0);
  endtask
  task automatic pulse_sdio;
    @(negedge clk); sdio = 1;
    @(negedge clk); sdio = 0;
  endtask
  task automatic rise(int u, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd[u] = 1; tick(3);
      rxd[u] = 0; tick(3);
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(2);
    chk({asleep, wake, grant, rej} == 0, "R1 reset flags", {asleep, wake, grant, rej}, 0);
    chk(wake_cause == 0 && rej_cause == 0, "R10 reset causes", wake_cause, 0);

    // R1: mode 0 is not a sleep request
    req(2'd0); tick(4);
    chk(!asleep, "R1 mode zero ignored", asleep, 0);

    // R4 R5: light sleep, Wi-Fi bit 5
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    chk(asleep, "R1 asleep after grant", asleep, 1);
    expect_ev(2, 11'h020, "R4 wifi wake"); wifi = 1; wait_awake("R4");
    wifi = 0; tick(4); clr_causes("R10");

    // R5: deep ignores Wi-Fi, takes touch
    expect_ev(0, 0, "R1 grant deep"); req(2'd2);
    wifi = 1; stay_asleep("R5 deep wifi");
    expect_ev(2, 11'h100, "R5 deep touch"); touch = 1; wait_awake("R5");
    wifi = 0; touch = 0; tick(4); clr_causes("R10");

    // R5: hibernation ignores GPIO, takes timer; R10 sticky
    expect_ev(0, 0, "R1 grant hib"); req(2'd3);
    gpio = 1; stay_asleep("R5 hib gpio");
    expect_ev(2, 11'h008, "R5 hib timer"); timer = 1; wait_awake("R5");
    gpio = 0; timer = 0; tick(4);
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    expect_ev(2, 11'h018, "R10 sticky wake cause"); pulse_sdio(); wait_awake("R10");
    clr_causes("R10");

    // R6: single pad, low level on pad 5
    ext0_sel = 5'd5; ext0_pol = 0; pad = '1; tick(4);
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    expect_ev(2, 11'h001, "R6 pad5 low"); pad[5] = 0; wait_awake("R6");
    ext0_sel = 5'd20; pad = '0; tick(4); clr_causes("R6");
    expect_ev(0, 0, "R1 grant deep"); req(2'd2);
    stay_asleep("R6 select out of range");
    expect_ev(2, 11'h008, "R6 timer after"); timer = 1; wait_awake("R6");
    timer = 0; ext0_sel = 5'd31; ext0_pol = 1; tick(4); clr_causes("R6");

    // R7: any-high in hibernation
    ext1_map = 18'h30000; ext1_pol = 1;
    expect_ev(0, 0, "R1 grant hib"); req(2'd3);
    expect_ev(2, 11'h002, "R7 any high"); pad[17] = 1; wait_awake("R7");
    pad = '0; tick(4); clr_causes("R7");
    // R7: all-low
    ext1_map = 18'h00003; ext1_pol = 0; pad = 18'h3; tick(4);
    expect_ev(0, 0, "R1 grant deep"); req(2'd2);
    pad[0] = 0; stay_asleep("R7 one pad low");
    expect_ev(2, 11'h002, "R7 all low"); pad[1] = 0; wait_awake("R7");
    tick(2); clr_causes("R7");
    // R7 empty map; R9 SDIO
    ext1_map = '0; tick(4);
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    stay_asleep("R7 empty map");
    expect_ev(2, 11'h010, "R9 sdio"); pulse_sdio(); wait_awake("R9");
    ext1_pol = 1; tick(2); clr_causes("R9");

    // R8: UART0 at threshold 3 needs 5 edges
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    rise(0, 4); stay_asleep("R8 four edges");
    expect_ev(2, 11'h040, "R8 uart0"); rise(0, 1); wait_awake("R8");
    clr_causes("R8");
    // R8: counter clears on grant
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    rise(1, 3);
    expect_ev(2, 11'h010, "R9 sdio"); pulse_sdio(); wait_awake("R9");
    clr_causes("R8");
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    rise(1, 2); stay_asleep("R8 cleared on grant");
    expect_ev(2, 11'h080, "R8 uart1"); rise(1, 3); wait_awake("R8");
    clr_causes("R8");

    // R2: UART1 still counted but never rejects
    rej_ena = '1; rej_light_en = 1;
    expect_ev(0, 0, "R2 uart no reject"); req(2'd1);
    expect_ev(2, 11'h010, "R9 sdio"); pulse_sdio(); wait_awake("R2");
    clr_causes("R2");
    // R2: Wi-Fi rejects light sleep
    wifi = 1; tick(4);
    expect_ev(1, 11'h020, "R2 reject light"); req(2'd1);
    chk(!asleep, "R2 stays awake", asleep, 0);
    // R2: deep reject disabled, grant then touch wake
    touch = 1; tick(4);
    expect_ev(0, 0, "R2 deep not rejected");
    expect_ev(2, 11'h100, "R5 touch wake"); req(2'd2); wait_awake("R2");
    // R2 R3: hibernation uses deep enable; cause accumulates
    wifi = 0; rej_deep_en = 1; tick(4);
    expect_ev(1, 11'h120, "R3 sticky reject"); req(2'd3);
    chk(rej_cause == 11'h120, "R3 held", rej_cause, 11'h120);
    clr_causes("R3");
    // R2: masked reject bit
    rej_ena = ~11'h100;
    expect_ev(0, 0, "R2 masked source");
    expect_ev(2, 11'h100, "R2 touch wake"); req(2'd1); wait_awake("R2");
    touch = 0; tick(4);

    // R1: request while asleep ignored
    expect_ev(0, 0, "R1 grant light"); req(2'd1);
    req(2'd2); stay_asleep("R1 request while asleep");
    expect_ev(2, 11'h400 | 11'h100, "R11 bt wake"); bt = 1; wait_awake("R11");
    bt = 0; tick(10);

    chk(exq.size() == 0, "R11 pending events", exq.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule